// File: doc/BRIEF.md
# LCD Raster Timing Generator

This block paces a parallel RGB panel. From a fixed input clock it derives a pixel strobe through an integer divisor. It counts pixels across each line and lines down each frame, and from those counts it drives the line sync, the frame sync and the data-enable window. It also produces a free-running pixel clock output. Each of the three clock-like outputs (pixel, line, frame) has its own polarity inversion input.

The line and frame geometry comes from configuration fields that are stored minus one. Active width is given in units of 16 pixels. Both axes run in the same order: sync pulse, back porch, active region, front porch. A run input starts the engine. Dropping the run input lets the current frame complete before the engine parks and zeroes its counters. Two sticky flags report frame completion and pixel starvation during active video. A one-cycle pulse on the matching clear input clears each flag.

Top module: `lcd_raster_timer`

## Requirements
- R1: The effective divisor D equals clk_div, or 2 when clk_div is 0 or 1. While busy, pclk_en pulses high for one cycle in the last cycle of every D-cycle pixel period. Before inversion, pclk is low for the first D/2 cycles of each pixel period (integer division) and high for the rest.
- R2: A line lasts (hsw+1)+(hbp+1)+(ppl_m1+1)*16+(hfp+1) pixel periods, in that order: sync, back porch, active, front porch. Before inversion, lclk is high exactly during the first hsw+1 pixel periods of each line, so a field value of 0 gives one period.
- R3: A frame lasts (vsw+1)+(vbp+1)+(lines_m1+1)+(vfp+1) lines, in the same order. Before inversion, fclk is high exactly during the first vsw+1 lines.
- R4: de is high exactly when the pixel lies in the horizontal active region and the line lies in the vertical active region.
- R5: inv_pclk, inv_lclk and inv_fclk each invert their own output. While idle, each of these outputs rests at its inverted-low level, which equals its inversion bit.
- R6: busy rises one cycle after raster_en is sampled high while idle. The first cycle after that is cycle 0 of pixel 0, line 0.
- R7: When raster_en is low at the last pixel strobe of a frame, busy falls on the following cycle. A later start begins again at pixel 0, line 0.
- R8: eof_stat becomes 1 on the cycle after the last pixel strobe of every frame. It stays set until a cycle with clr_eof high, and a new frame end wins over a clear in the same cycle.
- R9: sync_lost_stat becomes 1 on the cycle after px_starve is high while de is high. px_starve while de is low has no effect. clr_sync_lost clears the flag.
- R10: While not busy, de and pclk_en are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock |
| rst_n | input | 1 | Active-low synchronous reset |
| raster_en | input | 1 | Run request |
| clk_div | input | 8 | Pixel clock divisor |
| ppl_m1 | input | 6 | Active width in 16-pixel units, minus one |
| lines_m1 | input | 10 | Active lines minus one |
| hsw | input | 6 | Line sync width minus one |
| hbp | input | 8 | Horizontal back porch minus one |
| hfp | input | 8 | Horizontal front porch minus one |
| vsw | input | 6 | Frame sync width in lines, minus one |
| vbp | input | 8 | Vertical back porch minus one |
| vfp | input | 8 | Vertical front porch minus one |
| inv_pclk | input | 1 | Invert pixel clock output |
| inv_lclk | input | 1 | Invert line sync output |
| inv_fclk | input | 1 | Invert frame sync output |
| px_starve | input | 1 | Pixel source had no data this cycle |
| clr_eof | input | 1 | Clear frame-end flag |
| clr_sync_lost | input | 1 | Clear sync-lost flag |
| busy | output | 1 | Engine running |
| pclk_en | output | 1 | Pixel strobe |
| pclk | output | 1 | Pixel clock output |
| lclk | output | 1 | Line sync |
| fclk | output | 1 | Frame sync |
| de | output | 1 | Active video window |
| eof_stat | output | 1 | Sticky frame-end flag |
| sync_lost_stat | output | 1 | Sticky starvation flag |

## Verification
The assertions assume that clk_div and every geometry field stay constant while busy is high, because a change mid-frame would move the wrap points under the running counters. The stimulus respects this by loading a new configuration only after busy has fallen. Each configuration, whether directed or drawn from a seeded generator, is held for the whole run. Starvation pulses and clear pulses are single cycles, placed at positions the bench picks from its own model of the de window.

// File: rtl/lcd_raster_timer.sv
module lcd_raster_timer #(
  parameter int DIV_W   = 8,
  parameter int PPL_W   = 6,
  parameter int LINE_W  = 10,
  parameter int PORCH_W = 8,
  parameter int SYNC_W  = 6
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               raster_en,
  input  logic [DIV_W-1:0]   clk_div,
  input  logic [PPL_W-1:0]   ppl_m1,
  input  logic [LINE_W-1:0]  lines_m1,
  input  logic [SYNC_W-1:0]  hsw,
  input  logic [PORCH_W-1:0] hbp,
  input  logic [PORCH_W-1:0] hfp,
  input  logic [SYNC_W-1:0]  vsw,
  input  logic [PORCH_W-1:0] vbp,
  input  logic [PORCH_W-1:0] vfp,
  input  logic               inv_pclk,
  input  logic               inv_lclk,
  input  logic               inv_fclk,
  input  logic               px_starve,
  input  logic               clr_eof,
  input  logic               clr_sync_lost,
  output logic               busy,
  output logic               pclk_en,
  output logic               pclk,
  output logic               lclk,
  output logic               fclk,
  output logic               de,
  output logic               eof_stat,
  output logic               sync_lost_stat
);

  localparam int AW = (PPL_W + 5 > LINE_W + 1) ? PPL_W + 5 : LINE_W + 1;
  localparam int CW = AW + 2;

  logic             running;
  logic [DIV_W-1:0] dcnt, div_eff;
  logic [CW-1:0]    hcnt, vcnt;
  logic [CW-1:0]    h_sync_end, h_act_beg, h_act_end, h_total;
  logic [CW-1:0]    v_sync_end, v_act_beg, v_act_end, v_total;
  logic             tick, line_end, frame_end;
  logic             h_act, v_act;

  assign div_eff = (clk_div < DIV_W'(2)) ? DIV_W'(2) : clk_div;

  assign h_sync_end = CW'(hsw) + CW'(1);
  assign h_act_beg  = h_sync_end + CW'(hbp) + CW'(1);
  assign h_act_end  = h_act_beg + ((CW'(ppl_m1) + CW'(1)) << 4);
  assign h_total    = h_act_end + CW'(hfp) + CW'(1);

  assign v_sync_end = CW'(vsw) + CW'(1);
  assign v_act_beg  = v_sync_end + CW'(vbp) + CW'(1);
  assign v_act_end  = v_act_beg + CW'(lines_m1) + CW'(1);
  assign v_total    = v_act_end + CW'(vfp) + CW'(1);

  assign tick      = running && (dcnt >= div_eff - DIV_W'(1));
  assign line_end  = tick && (hcnt >= h_total - CW'(1));
  assign frame_end = line_end && (vcnt >= v_total - CW'(1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      running <= 1'b0;
      dcnt    <= '0;
      hcnt    <= '0;
      vcnt    <= '0;
    end else if (!running) begin
      running <= raster_en;
      dcnt    <= '0;
      hcnt    <= '0;
      vcnt    <= '0;
    end else begin
      dcnt <= tick ? '0 : dcnt + DIV_W'(1);
      if (tick)      hcnt <= line_end ? '0 : hcnt + CW'(1);
      if (line_end)  vcnt <= frame_end ? '0 : vcnt + CW'(1);
      if (frame_end && !raster_en) running <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      eof_stat       <= 1'b0;
      sync_lost_stat <= 1'b0;
    end else begin
      eof_stat       <= frame_end | (eof_stat & ~clr_eof);
      sync_lost_stat <= (de & px_starve) | (sync_lost_stat & ~clr_sync_lost);
    end
  end

  assign h_act   = (hcnt >= h_act_beg) && (hcnt < h_act_end);
  assign v_act   = (vcnt >= v_act_beg) && (vcnt < v_act_end);

  assign busy    = running;
  assign pclk_en = tick;
  assign pclk    = (running && (dcnt >= (div_eff >> 1))) ^ inv_pclk;
  assign lclk    = (running && (hcnt < h_sync_end)) ^ inv_lclk;
  assign fclk    = (running && (vcnt < v_sync_end)) ^ inv_fclk;
  assign de      = running && h_act && v_act;

  assert_strobe_gap_R1: assert property (@(posedge clk) disable iff (!rst_n)
    pclk_en |=> !pclk_en);

  assert_de_outside_sync_R4: assert property (@(posedge clk) disable iff (!rst_n)
    de |-> (lclk == inv_lclk) && (fclk == inv_fclk));

  assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !de && !pclk_en);

  assert_start_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && raster_en) |=> busy);

  assert_stop_at_frame_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> $past(frame_end));

  assert_eof_set_R8: assert property (@(posedge clk) disable iff (!rst_n)
    frame_end |=> eof_stat);

  assert_sync_lost_set_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (de && px_starve) |=> sync_lost_stat);

  assert_counter_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (hcnt < h_total) && (vcnt < v_total));

endmodule

// File: tb/tb_lcd_raster_timer.sv
module tb_lcd_raster_timer;
  localparam int CLK_P = 10;

  logic clk = 1'b0, rst_n = 1'b0, raster_en = 1'b0;
  logic [7:0] clk_div = '0;
  logic [5:0] ppl_m1 = '0, hsw = '0, vsw = '0;
  logic [9:0] lines_m1 = '0;
  logic [7:0] hbp = '0, hfp = '0, vbp = '0, vfp = '0;
  logic inv_pclk = 1'b0, inv_lclk = 1'b0, inv_fclk = 1'b0;
  logic px_starve = 1'b0, clr_eof = 1'b0, clr_sync_lost = 1'b0;
  logic busy, pclk_en, pclk, lclk, fclk, de, eof_stat, sync_lost_stat;

  int checks = 0, errors = 0;
  bit done = 0;

  lcd_raster_timer dut (
    .clk(clk), .rst_n(rst_n), .raster_en(raster_en), .clk_div(clk_div),
    .ppl_m1(ppl_m1), .lines_m1(lines_m1), .hsw(hsw), .hbp(hbp), .hfp(hfp),
    .vsw(vsw), .vbp(vbp), .vfp(vfp), .inv_pclk(inv_pclk), .inv_lclk(inv_lclk),
    .inv_fclk(inv_fclk), .px_starve(px_starve), .clr_eof(clr_eof),
    .clr_sync_lost(clr_sync_lost), .busy(busy), .pclk_en(pclk_en), .pclk(pclk),
    .lclk(lclk), .fclk(fclk), .de(de), .eof_stat(eof_stat),
    .sync_lost_stat(sync_lost_stat));

  always #(CLK_P/2) clk = ~clk;

  task automatic chk(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int dval();
    return (clk_div < 2) ? 2 : int'(clk_div);
  endfunction
  function automatic int hact();
    return (int'(ppl_m1) + 1) * 16;
  endfunction
  function automatic int htot();
    return int'(hsw) + int'(hbp) + int'(hfp) + 3 + hact();
  endfunction
  function automatic int vtot();
    return int'(vsw) + int'(vbp) + int'(vfp) + int'(lines_m1) + 4;
  endfunction

  task automatic setcfg(int dv, int pp, int ln, int hs, int hb, int hf,
                        int vs, int vb, int vf, bit ip, bit il, bit ifr);
    clk_div = 8'(dv); ppl_m1 = 6'(pp); lines_m1 = 10'(ln);
    hsw = 6'(hs); hbp = 8'(hb); hfp = 8'(hf);
    vsw = 6'(vs); vbp = 8'(vb); vfp = 8'(vf);
    inv_pclk = ip; inv_lclk = il; inv_fclk = ifr;
  endtask

  // mode 0: stop request at a random point in frame 0; 1: at its last cycle; 2: first cycle of frame 1
  task automatic run_cfg(int mode);
    int d, ht, vt, f, clear_at, stop;
    bit idle_done, act_done, idle_chk, act_chk;
    d = dval(); ht = htot(); vt = vtot(); f = d * ht * vt;
    clear_at = (mode == 0) ? int'($urandom_range(0, f - 1)) : (mode == 1) ? f - 1 : f;
    stop = ((clear_at + f) / f) * f;
    idle_done = 0; act_done = 0; idle_chk = 0; act_chk = 0;

    clr_eof = 1'b1; clr_sync_lost = 1'b1;
    @(negedge clk);
    clr_eof = 1'b0; clr_sync_lost = 1'b0;
    chk(eof_stat == 1'b0, "R8", "eof after clear", int'(eof_stat), 0);
    chk(sync_lost_stat == 1'b0, "R9", "sync_lost after clear", int'(sync_lost_stat), 0);
    raster_en = 1'b1;
    @(negedge clk);
    chk(busy == 1'b1, "R6", "busy after start", int'(busy), 1);

    for (int n = 0; ; n++) begin
      int ph, pix, h, v, ab, vb0;
      bit e_en, e_pc, e_l, e_f, e_de;
      if (n == f - 1) chk(eof_stat == 1'b0, "R8", "eof before frame end", int'(eof_stat), 0);
      if (n == f)     chk(eof_stat == 1'b1, "R8", "eof after frame end", int'(eof_stat), 1);
      if (n == stop) begin
        chk(busy == 1'b0, "R7", "busy at stop", int'(busy), 0);
        chk(de == 1'b0, "R10", "de idle", int'(de), 0);
        chk(pclk_en == 1'b0, "R10", "pclk_en idle", int'(pclk_en), 0);
        chk(lclk == inv_lclk, "R5", "lclk idle", int'(lclk), int'(inv_lclk));
        chk(fclk == inv_fclk, "R5", "fclk idle", int'(fclk), int'(inv_fclk));
        chk(pclk == inv_pclk, "R5", "pclk idle", int'(pclk), int'(inv_pclk));
        break;
      end
      chk(busy == 1'b1, "R7", "busy before frame end", int'(busy), 1);
      ph = n % d; pix = n / d; h = pix % ht; v = (pix / ht) % vt;
      ab = int'(hsw) + int'(hbp) + 2; vb0 = int'(vsw) + int'(vbp) + 2;
      e_en = (ph == d - 1);
      e_pc = (ph >= d / 2) ^ inv_pclk;
      e_l  = (h < int'(hsw) + 1) ^ inv_lclk;
      e_f  = (v < int'(vsw) + 1) ^ inv_fclk;
      e_de = (h >= ab) && (h < ab + hact()) && (v >= vb0) && (v < vb0 + int'(lines_m1) + 1);
      if (pclk_en != e_en) chk(0, "R1", $sformatf("pclk_en n=%0d", n), int'(pclk_en), int'(e_en));
      else checks++;
      if (pclk != e_pc) chk(0, "R1", $sformatf("pclk n=%0d", n), int'(pclk), int'(e_pc));
      else checks++;
      if (lclk != e_l) chk(0, "R2", $sformatf("lclk n=%0d", n), int'(lclk), int'(e_l));
      else checks++;
      if (fclk != e_f) chk(0, "R3", $sformatf("fclk n=%0d", n), int'(fclk), int'(e_f));
      else checks++;
      if (de != e_de) chk(0, "R4", $sformatf("de n=%0d", n), int'(de), int'(e_de));
      else checks++;
      if (idle_chk) chk(sync_lost_stat == 1'b0, "R9", "starve outside de", int'(sync_lost_stat), 0);
      if (act_chk)  chk(sync_lost_stat == 1'b1, "R9", "starve inside de", int'(sync_lost_stat), 1);
      idle_chk = 0; act_chk = 0;
      px_starve = 1'b0;
      if (!idle_done && !e_de && n >= 3) begin
        px_starve = 1'b1; idle_done = 1; idle_chk = 1;
      end else if (idle_done && !act_done && e_de) begin
        px_starve = 1'b1; act_done = 1; act_chk = 1;
      end
      if (n == clear_at) raster_en = 1'b0;
      @(negedge clk);
    end
    px_starve = 1'b0;
    clr_eof = 1'b1;
    @(negedge clk);
    clr_eof = 1'b0;
    chk(eof_stat == 1'b0, "R8", "eof cleared", int'(eof_stat), 0);
    chk(busy == 1'b0, "R10", "stays idle", int'(busy), 0);
  endtask

  initial begin
    int seed;
    seed = int'($urandom(20240611));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(busy == 1'b0, "R10", "reset busy", int'(busy), 0);
    chk(de == 1'b0, "R10", "reset de", int'(de), 0);
    chk(eof_stat == 1'b0, "R8", "reset eof", int'(eof_stat), 0);
    chk(sync_lost_stat == 1'b0, "R9", "reset sync_lost", int'(sync_lost_stat), 0);
    chk(lclk == 1'b0, "R5", "reset lclk", int'(lclk), 0);

    setcfg(0, 0, 1, 0, 0, 0, 0, 0, 0, 0, 0, 0);  run_cfg(1);
    setcfg(1, 0, 2, 2, 1, 3, 1, 2, 0, 1, 1, 1);  run_cfg(2);
    setcfg(3, 63, 0, 1, 2, 1, 0, 0, 0, 0, 0, 0); run_cfg(1);
    setcfg(5, 1, 3, 3, 0, 2, 2, 0, 1, 0, 1, 0);  run_cfg(0);
    for (int i = 0; i < 6; i++) begin
      setcfg(int'($urandom_range(0, 5)), int'($urandom_range(0, 1)), int'($urandom_range(0, 3)),
             int'($urandom_range(0, 3)), int'($urandom_range(0, 3)), int'($urandom_range(0, 3)),
             int'($urandom_range(0, 3)), int'($urandom_range(0, 3)), int'($urandom_range(0, 3)),
             1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)));
      run_cfg(0);
    end

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL R7 watchdog actual=running expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule